// File: doc/BRIEF.md
# Dual-Mode Stereo Serial Word Receiver

This block turns a bit-serial stereo audio stream into pairs of signed 16-bit words. It lives in a fast system clock domain. The external bit clock, the frame clock and the data lines are oversampled through synchronizers. A rising bit-clock edge seen on the synchronized bit clock samples one bit. Data and frame transitions are expected on the falling edges. Each high phase and each low phase of the bit clock must last at least three system clock cycles.

A static mode input selects one of two framing schemes:

- **Shared-line mode:** the two channels alternate on one data line. The frame level tells left from right. A second input (`aux_i`) serves as the polarity selector.
- **Two-line mode:** `aux_i` becomes the right-channel data line. Both channels arrive at the same time. Each word begins at a falling edge of the frame clock.

A finished stereo pair appears on `left_o` and `right_o` with a one-cycle `valid_o` strobe, at a fixed bit-clock latency. The output has no back-pressure. The stream is paced by the external bit clock and cannot be stalled, so the consumer must take the pair in the cycle `valid_o` is high. The outputs then hold until the next strobe.

Top module: `stereo_word_rx`

## Requirements
- R1: With `two_line_i` = 0, both channels share `sdata_i`, and `aux_i` is the polarity. With `aux_i` = 0, a word sent while `frame_i` is high is left and one sent while it is low is right. With `aux_i` = 1, the mapping is the other way round.
- R2: With `two_line_i` = 1, the left word is taken from `sdata_i` and the right word from `aux_i` during the same 16 bits. A word starts at the bit whose sampling edge first sees `frame_i` low after it was high. The rising of `frame_i` inside a word has no effect.
- R3: A word is exactly 16 bits, two's complement, MSB first. One bit is sampled on each rising edge of `bclk_i`, with data and frame changes made while `bclk_i` is low.
- R4: `left_o` and `right_o` both change on the 5th rising `bclk_i` edge after the edge that sampled the LSB of the pair-completing word. This is 4.5 bit periods after the falling edge that ends the LSB. `valid_o` is high for exactly one system cycle at that update, and the outputs never change at any other time.
- R5: In shared-line mode, a completed left word is staged and is paired with the next completed right word. A right word that completes with no staged left word is discarded and produces no output.
- R6: A bit clock that stops between words is accepted. In shared-line mode the frame may reverse anywhere in such a gap; in two-line mode the frame may fall anywhere in such a gap. Output latency is counted in bit-clock edges only, so gap length has no effect on the result.
- R7: Every word boundary (a frame reversal in shared-line mode, a frame fall in two-line mode) restarts the bit count. A word cut short by an early boundary is discarded, and the next full words are received correctly.
- R8: A synchronous active-high `rst` clears `left_o`, `right_o`, `valid_o`, the staging and the bit count. After reset, no bit is taken until a word boundary is seen between two bit-clock edges after reset. The first edge after reset only records the frame level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| two_line_i | input | 1 | Static mode: 0 shared-line, 1 two-line |
| bclk_i | input | 1 | External bit clock, may be gated between words |
| frame_i | input | 1 | Left/right clock (shared-line) or word clock (two-line) |
| sdata_i | input | 1 | Shared data line, or left data line in two-line mode |
| aux_i | input | 1 | Polarity select in shared-line mode, right data line in two-line mode |
| left_o | output | 16 | Left sample, two's complement |
| right_o | output | 16 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is loaded |

## Verification
The hardest situation to reach is recovery from a broken framing. One case is a word cut short by an early frame reversal, which leaves a right word with no staged partner. Another is the first word after reset, which lacks a preceding edge from which a boundary can be seen. The bench drives these cases on purpose: it sends a 9-bit partial left word followed by full words, and it starts a stream directly after reset with no preamble. It then checks that exactly one pair emerges, with the expected values. Gated-clock runs place the frame change inside stopped-clock gaps of different lengths. The latency is checked by counting bench-side bit-clock edges rather than time.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;
  typedef enum logic {
    MODE_SHARED   = 1'b0,
    MODE_TWO_LINE = 1'b1
  } rx_mode_e;

  // Lane positions inside the synchronized input vector
  localparam int unsigned LANE_BCLK  = 0;
  localparam int unsigned LANE_FRAME = 1;
  localparam int unsigned LANE_SDATA = 2;
  localparam int unsigned LANE_AUX   = 3;
  localparam int unsigned LANE_COUNT = 4;
endpackage

// File: rtl/swr_input_sync.sv
`timescale 1ns/1ps
module swr_input_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] sync_o,
  output logic             bclk_rise_o
);
  logic bclk_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

  // Lane 0 carries the bit clock; a rising edge gives a one-cycle strobe
  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= sync_o[0];
  end
  assign bclk_rise_o = sync_o[0] & ~bclk_q;
endmodule

// File: rtl/swr_deser.sv
`timescale 1ns/1ps
module swr_deser #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              two_line_i,
  input  logic              frame_i,
  input  logic              sd_a_i,
  input  logic              sd_b_i,
  output logic              done_o,
  output logic              lvl_o,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic             prev_f;
  logic             have_prev;
  logic             boundary;
  logic             shift_en;
  logic [CNT_W-1:0] cnt;     // CNT_FULL means idle / waiting for a boundary
  logic [1:0]       lane_bit;
  logic [WORD_W-1:0] lane_sh [2];

  always_comb begin
    if (two_line_i) boundary = have_prev && prev_f && !frame_i;
    else            boundary = have_prev && (prev_f != frame_i);
  end

  assign shift_en = rise_i && (boundary || (cnt < CNT_FULL));
  assign lane_bit = {sd_b_i, sd_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst)           lane_sh[g] <= '0;
      else if (shift_en) lane_sh[g] <= {lane_sh[g][WORD_W-2:0], lane_bit[g]};
    end
  end

  assign word_a_o = lane_sh[0];
  assign word_b_o = lane_sh[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_f    <= 1'b0;
      have_prev <= 1'b0;
      cnt       <= CNT_FULL;
      lvl_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        prev_f    <= frame_i;
        have_prev <= 1'b1;
        if (boundary) begin
          cnt   <= CNT_W'(1);
          lvl_o <= frame_i;
        end else if (cnt < CNT_FULL) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) done_o <= 1'b1;
        end
      end
    end
  end

  // R3: a finished word always follows a sampling edge
  assert_done_after_edge_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(rise_i));
  // R3: a word is reported only with a full bit count
  assert_done_full_count_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt == CNT_FULL));
  // R7: a boundary edge restarts counting at the first bit
  assert_restart_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    (rise_i && boundary) |=> (cnt == CNT_W'(1)) && !done_o);
endmodule

// File: rtl/swr_pairer.sv
`timescale 1ns/1ps
module swr_pairer #(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned UPDATE_EDGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              two_line_i,
  input  logic              pol_i,
  input  logic              done_i,
  input  logic              lvl_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  localparam int unsigned LAT_W = $clog2(UPDATE_EDGES + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(UPDATE_EDGES - 1);

  logic              is_left;
  logic [WORD_W-1:0] stage;
  logic              stage_v;
  logic [WORD_W-1:0] pend_l;
  logic [WORD_W-1:0] pend_r;
  logic              pend;
  logic [LAT_W-1:0]  lat;

  assign is_left = lvl_i ^ pol_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage   <= '0;
      stage_v <= 1'b0;
      pend_l  <= '0;
      pend_r  <= '0;
      pend    <= 1'b0;
      lat     <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (two_line_i) begin
          pend_l <= word_a_i;
          pend_r <= word_b_i;
          pend   <= 1'b1;
          lat    <= '0;
        end else if (is_left) begin
          stage   <= word_a_i;
          stage_v <= 1'b1;
        end else if (stage_v) begin
          pend_l  <= stage;
          pend_r  <= word_a_i;
          pend    <= 1'b1;
          lat     <= '0;
          stage_v <= 1'b0;
        end
      end else if (pend && rise_i) begin
        if (lat == LAT_LAST) begin
          left_o  <= pend_l;
          right_o <= pend_r;
          valid_o <= 1'b1;
          pend    <= 1'b0;
        end else begin
          lat <= lat + 1'b1;
        end
      end
    end
  end

  // R4: strobe lasts a single cycle
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R4: outputs move only together with the strobe
  assert_outputs_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  // R4: a load is always preceded by a waiting pair
  assert_load_after_wait_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(pend));
  // R5: pairing only ever happens from a staged left word in shared-line mode
  assert_pair_needs_stage_R5: assert property (@(posedge clk) disable iff (rst)
    (done_i && !two_line_i && !is_left && !stage_v) |=> !pend || $past(pend));
endmodule

// File: rtl/stereo_word_rx.sv
`timescale 1ns/1ps
module stereo_word_rx
  import swr_pkg::*;
#(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned UPDATE_EDGES = 5,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              two_line_i,
  input  logic              bclk_i,
  input  logic              frame_i,
  input  logic              sdata_i,
  input  logic              aux_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  rx_mode_e                mode;
  logic                    two_line;
  logic [LANE_COUNT-1:0]   raw;
  logic [LANE_COUNT-1:0]   syn;
  logic                    rise;
  logic                    done;
  logic                    lvl;
  logic [WORD_W-1:0]       word_a;
  logic [WORD_W-1:0]       word_b;

  assign mode     = rx_mode_e'(two_line_i);
  assign two_line = (mode == MODE_TWO_LINE);

  always_comb begin
    raw             = '0;
    raw[LANE_BCLK]  = bclk_i;
    raw[LANE_FRAME] = frame_i;
    raw[LANE_SDATA] = sdata_i;
    raw[LANE_AUX]   = aux_i;
  end

  swr_input_sync #(.STAGES(SYNC_STAGES), .LANES(LANE_COUNT)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .raw_i       (raw),
    .sync_o      (syn),
    .bclk_rise_o (rise)
  );

  swr_deser #(.WORD_W(WORD_W)) u_deser (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .two_line_i (two_line),
    .frame_i    (syn[LANE_FRAME]),
    .sd_a_i     (syn[LANE_SDATA]),
    .sd_b_i     (syn[LANE_AUX]),
    .done_o     (done),
    .lvl_o      (lvl),
    .word_a_o   (word_a),
    .word_b_o   (word_b)
  );

  swr_pairer #(.WORD_W(WORD_W), .UPDATE_EDGES(UPDATE_EDGES)) u_pair (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .two_line_i (two_line),
    .pol_i      (syn[LANE_AUX]),
    .done_i     (done),
    .lvl_i      (lvl),
    .word_a_i   (word_a),
    .word_b_i   (word_b),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o)
  );
endmodule

// File: tb/stereo_word_rx_test.sv
`timescale 1ns/1ps
module stereo_word_rx_test;
  localparam int HALF = 80;   // bit clock half period in ns (4 system cycles)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        two_line = 1'b0;
  logic        bclk = 1'b0;
  logic        frame = 1'b0;
  logic        sdata = 1'b0;
  logic        aux = 1'b0;
  logic [15:0] left_o;
  logic [15:0] right_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;
  int rise_cnt = 0;

  logic [15:0] exp_l [0:31];
  logic [15:0] exp_r [0:31];
  int          exp_rise [0:31];
  int          n_exp = 0;
  logic [15:0] got_l [0:31];
  logic [15:0] got_r [0:31];
  int          got_rise [0:31];
  int          n_got = 0;

  always #10 clk = ~clk;

  stereo_word_rx uut (
    .clk(clk), .rst(rst), .two_line_i(two_line), .bclk_i(bclk),
    .frame_i(frame), .sdata_i(sdata), .aux_i(aux),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(posedge bclk) rise_cnt++;

  always @(negedge clk) begin
    if (valid_o && n_got < 32) begin
      got_l[n_got]    = left_o;
      got_r[n_got]    = right_o;
      got_rise[n_got] = rise_cnt;
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic a, input logic b, input logic f);
    bclk = 1'b0; sdata = a; aux = b; frame = f;
    #HALF;
    bclk = 1'b1;
    #HALF;
  endtask

  task automatic gap(input logic f, input int n);
    bclk = 1'b0; frame = f;
    #(2 * HALF * n);
  endtask

  task automatic mux_word(input logic [15:0] w, input logic f, input logic pol);
    for (int i = 15; i >= 0; i--) bit_out(w[i], pol, f);
  endtask

  task automatic tl_word(input logic [15:0] l, input logic [15:0] r);
    for (int i = 15; i >= 0; i--) bit_out(l[i], r[i], (i < 12));
  endtask

  task automatic expect_pair(input logic [15:0] l, input logic [15:0] r);
    exp_l[n_exp] = l;
    exp_r[n_exp] = r;
    exp_rise[n_exp] = rise_cnt + 5;
    n_exp++;
  endtask

  // R8: reset clears the outputs
  task automatic do_reset(input logic mode, input logic aux_lvl);
    bclk = 1'b0; frame = 1'b0; sdata = 1'b0; aux = aux_lvl; two_line = mode;
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(left_o == 16'h0, "R8", "left after reset", left_o, 0);
    chk(right_o == 16'h0, "R8", "right after reset", right_o, 0);
    chk(valid_o == 1'b0, "R8", "valid after reset", valid_o, 0);
    n_exp = 0;
    n_got = 0;
  endtask

  task automatic compare(input string req);
    repeat (6) @(negedge clk);
    chk(n_got == n_exp, req, "pair count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_l[i] == exp_l[i], req, "left value", got_l[i], exp_l[i]);
      chk(got_r[i] == exp_r[i], req, "right value", got_r[i], exp_r[i]);
      // R4: update lands on the fifth bit-clock rise after the LSB
      chk(got_rise[i] == exp_rise[i], "R4", "update edge", got_rise[i], exp_rise[i]);
    end
  endtask

  // R1 R3 R4 R5: shared line, polarity 0, free-running clock
  task automatic t_shared_pol0();
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b0, 1'b0);
    mux_word(16'h7FFF, 1'b1, 1'b0);
    mux_word(16'h8000, 1'b0, 1'b0); expect_pair(16'h7FFF, 16'h8000);
    mux_word(16'h1234, 1'b1, 1'b0);
    mux_word(16'hFEDC, 1'b0, 1'b0); expect_pair(16'h1234, 16'hFEDC);
    mux_word(16'h0001, 1'b1, 1'b0);
    mux_word(16'hFFFF, 1'b0, 1'b0); expect_pair(16'h0001, 16'hFFFF);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0, 1'b1);
    compare("R1");
  endtask

  // R1: polarity 1, left while frame low
  task automatic t_shared_pol1();
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b1, 1'b1);
    mux_word(16'hA5A5, 1'b0, 1'b1);
    mux_word(16'h5A5A, 1'b1, 1'b1); expect_pair(16'hA5A5, 16'h5A5A);
    mux_word(16'h0000, 1'b0, 1'b1);
    mux_word(16'h8001, 1'b1, 1'b1); expect_pair(16'h0000, 16'h8001);
    for (int i = 0; i < 6; i++) bit_out(1'b1, 1'b1, 1'b0);
    compare("R1");
  endtask

  // R2: two data lines, word clock falls at MSB
  task automatic t_two_line();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) bit_out(1'b1, 1'b1, 1'b1);
    tl_word(16'h1357, 16'h8642); expect_pair(16'h1357, 16'h8642);
    tl_word(16'h7FFE, 16'h0002); expect_pair(16'h7FFE, 16'h0002);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0, 1'b0);
    compare("R2");
  endtask

  // R6: gated clock, frame reverses inside the gaps
  task automatic t_shared_gated();
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 2; i++) bit_out(1'b0, 1'b0, 1'b0);
    gap(1'b1, 4); mux_word(16'h4321, 1'b1, 1'b0);
    gap(1'b0, 3); mux_word(16'hBCDE, 1'b0, 1'b0); expect_pair(16'h4321, 16'hBCDE);
    gap(1'b1, 5); mux_word(16'h0F0F, 1'b1, 1'b0);
    gap(1'b0, 2); mux_word(16'hF0F0, 1'b0, 1'b0); expect_pair(16'h0F0F, 16'hF0F0);
    gap(1'b1, 3);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0, 1'b1);
    compare("R6");
  endtask

  // R6 R2: gated clock, word clock falls inside the gaps
  task automatic t_two_line_gated();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b0, 1'b1);
    gap(1'b0, 4); tl_word(16'hC0DE, 16'h3EEF); expect_pair(16'hC0DE, 16'h3EEF);
    gap(1'b0, 3); tl_word(16'h0102, 16'hFDFE); expect_pair(16'h0102, 16'hFDFE);
    gap(1'b0, 2);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0, 1'b0);
    compare("R6");
  endtask

  // R7 R5: short left word, then unpaired right dropped, then recovery
  task automatic t_misaligned();
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) bit_out(1'b1, 1'b0, 1'b1);
    mux_word(16'h1111, 1'b0, 1'b0);
    mux_word(16'h2222, 1'b1, 1'b0);
    mux_word(16'h3333, 1'b0, 1'b0); expect_pair(16'h2222, 16'h3333);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0, 1'b1);
    compare("R7");
  endtask

  // R8: no preamble after reset, first boundary only on second word
  task automatic t_reset_resync();
    do_reset(1'b0, 1'b0);
    mux_word(16'h0A0A, 1'b1, 1'b0);
    mux_word(16'h0B0B, 1'b0, 1'b0);
    mux_word(16'h0C0C, 1'b1, 1'b0);
    mux_word(16'h0D0D, 1'b0, 1'b0); expect_pair(16'h0C0C, 16'h0D0D);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0, 1'b1);
    compare("R8");
  endtask

  initial begin
    t_shared_pol0();
    t_shared_pol1();
    t_two_line();
    t_shared_gated();
    t_two_line_gated();
    t_misaligned();
    t_reset_resync();
    do_reset(1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule